// File: doc/BRIEF.md
# Wrapping Burst Address Generator

This block sits in front of a synchronous memory array and turns a single strobed start address into the word addresses of a four-beat burst. When an access is strobed, the full address is captured. The two low bits become the start point of a small burst counter. Each later clock edge with the advance input asserted moves the burst to its next beat. The upper address bits do not change until the next accepted strobe.

Two strobes can start an access. The processor-side strobe has fixed priority over the controller-side strobe. The processor-side strobe only counts when the chip select is asserted. The controller-side strobe is accepted whatever the chip select does.

A static order input picks the beat order. With it low, the order is linear: the start plus the beat count, modulo four. With it high, the order is interleaved: the start XOR the beat count. The output address is the registered upper bits joined to the mapped low bits. The asynchronous reset is released synchronously inside the block.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, addr_out is all zeros. Until the first accepted strobe, asserting adv_n low leaves addr_out unchanged.
- R2: An accepted strobe at a rising edge makes addr_out equal addr_in after that edge. The low two bits give the start point and the beat count goes to 0. A processor strobe (strobe_proc_n low with sel_n low) is accepted, and so is a controller strobe (strobe_ctrl_n low).
- R3: Both strobes low with sel_n low loads the address. When strobe_proc_n is low with sel_n high, the controller strobe alone decides: strobe_ctrl_n low still loads the address.
- R4: strobe_proc_n low with sel_n high and strobe_ctrl_n high is ignored, and addr_out keeps its value.
- R5: With no accepted strobe and adv_n high, addr_out holds its value.
- R6: With order_sel = 0 (linear), each advance (adv_n low, no strobe, burst started) sets the low two bits to the start plus the beat count, modulo 4. For example, start 2 gives 2, 3, 0, 1.
- R7: With order_sel = 1 (interleaved), the low two bits equal the start XOR the beat count. Start 1 gives 1, 0, 3, 2, and start 2 gives 2, 3, 0, 1.
- R8: Bits above the low two stay fixed for the whole burst. A fifth and later advance keep wrapping through the same four words.
- R9: An accepted strobe in mid-burst restarts from the new address at beat 0, even when adv_n is low at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strobe_proc_n | input | 1 | Processor-side address strobe, active low, gated by sel_n |
| strobe_ctrl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Static order select: 0 linear, 1 interleaved |
| sel_n | input | 1 | Chip select, active low, gates the processor strobe |
| addr_in | input | ADDR_W | Start address presented with a strobe |
| addr_out | output | ADDR_W | Current burst word address |

## Verification
The bench goes after the points where the two orders differ. From start 1, a design that swapped or mixed up the orders would give 2 instead of 0 on the first advance. It also checks the wrap past the fourth beat, where a counter wider than two bits would carry into the upper address bits. Two strobe cases are covered. A processor strobe with the chip deselected must not load. A controller strobe at the same edge must still load: a design that let the gated processor strobe block it would keep the old address. A strobe that arrives together with an advance must restart at beat 0. A design that gave the advance priority would show beat 1 of the new address instead. The bench also checks that an advance before any strobe does nothing, so a design without a burst-active flag would move off zero.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PROC = 2'd1,
    SRC_CTRL = 2'd2
  } load_src_e;
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/burst_strobe_arb.sv
module burst_strobe_arb
  import burst_pkg::*;
(
  input  logic      strobe_proc_n,
  input  logic      strobe_ctrl_n,
  input  logic      sel_n,
  output load_src_e load_src,
  output logic      load
);
  logic proc_ok;
  logic ctrl_ok;

  always_comb begin
    proc_ok = !strobe_proc_n && !sel_n;
    ctrl_ok = !strobe_ctrl_n;
    if (proc_ok)      load_src = SRC_PROC;
    else if (ctrl_ok) load_src = SRC_CTRL;
    else              load_src = SRC_NONE;
    load = (load_src != SRC_NONE);
  end
endmodule

// File: rtl/burst_counter.sv
module burst_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [CNT_W-1:0] start_in,
  output logic [CNT_W-1:0] start_q,
  output logic [CNT_W-1:0] beat_q,
  output logic             active_q
);
  logic [CNT_W-1:0] start_d;
  logic [CNT_W-1:0] beat_d;
  logic             active_d;
  logic             cnt_en;

  always_comb begin
    cnt_en   = load || (adv && active_q);
    start_d  = start_q;
    beat_d   = beat_q;
    active_d = active_q;
    if (load) begin
      start_d  = start_in;
      beat_d   = '0;
      active_d = 1'b1;
    end else if (adv && active_q) begin
      beat_d   = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= '0;
      beat_q   <= '0;
      active_q <= 1'b0;
    end else if (cnt_en) begin
      start_q  <= start_d;
      beat_q   <= beat_d;
      active_q <= active_d;
    end
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  order_e           order,
  input  logic [CNT_W-1:0] start,
  input  logic [CNT_W-1:0] beat,
  output logic [CNT_W-1:0] word
);
  logic [CNT_W-1:0] lin_word;
  logic [CNT_W-1:0] xor_word;

  genvar gi;
  generate
    for (gi = 0; gi < CNT_W; gi++) begin : g_xor
      assign xor_word[gi] = start[gi] ^ beat[gi];
    end
  endgenerate

  assign lin_word = start + beat;

  always_comb begin
    case (order)
      ORD_INTERLEAVE: word = xor_word;
      default:        word = lin_word;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_proc_n,
  input  logic              strobe_ctrl_n,
  input  logic              adv_n,
  input  logic              order_sel,
  input  logic              sel_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int UP_W = ADDR_W - CNT_W;

  logic             rst_sync_n;
  load_src_e        load_src;
  logic             load;
  logic [UP_W-1:0]  upper_q;
  logic [UP_W-1:0]  upper_d;
  logic [CNT_W-1:0] start_low;
  logic [CNT_W-1:0] beat_low;
  logic             burst_active;
  logic [CNT_W-1:0] word_low;
  order_e           order;

  burst_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  burst_strobe_arb u_arb (
    .strobe_proc_n (strobe_proc_n),
    .strobe_ctrl_n (strobe_ctrl_n),
    .sel_n         (sel_n),
    .load_src      (load_src),
    .load          (load)
  );

  always_comb begin
    upper_d = upper_q;
    if (load) upper_d = addr_in[ADDR_W-1:CNT_W];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  upper_q <= '0;
    else if (load)    upper_q <= upper_d;
  end

  burst_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (load),
    .adv      (!adv_n),
    .start_in (addr_in[CNT_W-1:0]),
    .start_q  (start_low),
    .beat_q   (beat_low),
    .active_q (burst_active)
  );

  assign order = order_e'(order_sel);

  burst_order_map #(.CNT_W(CNT_W)) u_map (
    .order (order),
    .start (start_low),
    .beat  (beat_low),
    .word  (word_low)
  );

  assign addr_out = {upper_q, word_low};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strobe_proc_n,
  input logic              strobe_ctrl_n,
  input logic              adv_n,
  input logic              order_sel,
  input logic              sel_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic              active,
  input logic [CNT_W-1:0]  start_low
);
  logic acc;
  logic [CNT_W-1:0] low;
  logic [CNT_W-1:0] rel;
  assign acc = (!strobe_proc_n && !sel_n) || !strobe_ctrl_n;
  assign low = addr_out[CNT_W-1:0];
  assign rel = low ^ start_low;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> addr_out == $past(addr_in));

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !active) |=> $stable(addr_out));

  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_proc_n && sel_n && strobe_ctrl_n && adv_n) |=> $stable(addr_out));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && adv_n) |=> $stable(addr_out));

  p_linear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !adv_n && active && !order_sel && $stable(order_sel))
      |=> low == CNT_W'($past(low) + 1'b1));

  p_inter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !adv_n && active && order_sel)
      |=> rel == CNT_W'($past(rel) + 1'b1));

  p_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(addr_out[ADDR_W-1:CNT_W]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .strobe_proc_n (strobe_proc_n),
  .strobe_ctrl_n (strobe_ctrl_n),
  .adv_n         (adv_n),
  .order_sel     (order_sel),
  .sel_n         (sel_n),
  .addr_in       (addr_in),
  .addr_out      (addr_out),
  .active        (burst_active),
  .start_low     (start_low)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int AW = 18;

  logic          clk;
  logic          rst_n;
  logic          sp_n, sc_n, adv_n, ord, sel_n;
  logic [AW-1:0] a_in;
  logic [AW-1:0] a_out;
  int            n_chk;
  int            n_fail;

  burst_addr_gen #(.ADDR_W(AW), .CNT_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .strobe_proc_n(sp_n), .strobe_ctrl_n(sc_n),
    .adv_n(adv_n), .order_sel(ord), .sel_n(sel_n), .addr_in(a_in), .addr_out(a_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [1:0] exp_low(logic m, logic [1:0] s, logic [1:0] b);
    return m ? (s ^ b) : 2'(s + b);
  endfunction

  task automatic check(string req, logic [AW-1:0] got, logic [AW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(logic p, logic c, logic s, logic a, logic [AW-1:0] ad);
    @(negedge clk);
    sp_n = p; sc_n = c; sel_n = s; adv_n = a; a_in = ad;
    @(posedge clk); #1;
    sp_n = 1'b1; sc_n = 1'b1; adv_n = 1'b1; sel_n = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset", a_out, '0);
    cyc(1, 1, 0, 0, 18'h3FFFF);
    check("R1 adv before strobe", a_out, '0);
  endtask

  task automatic t_load();
    cyc(0, 1, 0, 1, 18'h12345);
    check("R2 proc load", a_out, 18'h12345);
    cyc(1, 0, 1, 1, 18'h2A5A6);
    check("R2 ctrl load", a_out, 18'h2A5A6);
  endtask

  task automatic t_order(logic m, logic [AW-1:0] base, string req);
    ord = m;
    cyc(0, 1, 0, 1, base);
    check(req, a_out, base);
    for (int b = 1; b < 4; b++) begin
      cyc(1, 1, 0, 0, 18'h0);
      check(req, a_out, {base[AW-1:2], exp_low(m, base[1:0], 2'(b))});
    end
  endtask

  task automatic t_wrap();
    ord = 1'b0;
    cyc(1, 0, 0, 1, 18'h3FFFE);
    for (int b = 1; b < 7; b++) begin
      cyc(1, 1, 0, 0, 18'h0);
      check("R8 wrap upper fixed", a_out, {16'hFFFF, exp_low(1'b0, 2'd2, 2'(b))});
    end
  endtask

  task automatic t_hold();
    cyc(0, 1, 0, 1, 18'h01111);
    cyc(1, 1, 0, 0, 18'h0);
    cyc(1, 1, 0, 1, 18'h3FFFF);
    check("R5 hold", a_out, 18'h01112);
    cyc(1, 1, 1, 1, 18'h00000);
    check("R5 hold", a_out, 18'h01112);
  endtask

  task automatic t_gate();
    cyc(0, 1, 0, 1, 18'h0ABC0);
    cyc(0, 1, 1, 1, 18'h15553);
    check("R4 proc ignored when deselected", a_out, 18'h0ABC0);
  endtask

  task automatic t_prio();
    cyc(0, 0, 1, 1, 18'h23457);
    check("R3 ctrl loads when proc gated", a_out, 18'h23457);
    cyc(0, 0, 0, 1, 18'h1F0F1);
    check("R3 both strobes load", a_out, 18'h1F0F1);
  endtask

  task automatic t_restart();
    ord = 1'b1;
    cyc(0, 1, 0, 1, 18'h04441);
    cyc(1, 1, 0, 0, 18'h0);
    cyc(1, 1, 0, 0, 18'h0);
    check("R9 mid burst", a_out, 18'h04443);
    cyc(1, 0, 0, 0, 18'h08882);
    check("R9 restart beats advance", a_out, 18'h08882);
    cyc(1, 1, 0, 0, 18'h0);
    check("R9 next after restart", a_out, 18'h08883);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    sp_n = 1'b1; sc_n = 1'b1; adv_n = 1'b1; ord = 1'b0; sel_n = 1'b0; a_in = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_load();
    t_order(1'b0, 18'h2B6E2, "R6 linear start 2");
    t_order(1'b1, 18'h11111, "R7 interleave start 1");
    t_order(1'b1, 18'h33332, "R7 interleave start 2");
    t_wrap();
    t_hold();
    t_gate();
    t_prio();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule